// File: doc/BRIEF.md
# TDC Readout Test Histogrammer

This block sits on the test side of a 32-channel time-to-digital converter and checks the decoded data stream that comes back from it. Each accepted stream word is either an event header or a hit. For header words, the block counts events whose header bits differ from a programmed expected value, and it keeps an event total. That total is compared against the number of trigger strobes it was told were issued. For hit words, it keeps one hit counter per channel. It also fills a 64-bin time histogram, one bin per 6-bit time code, for a single selected channel.

Two verdicts are derived from the counts. A channel-liveness mask flags every channel of the active round parity (even or odd, picked by a control bit) that has collected fewer hits than the fixed quota. A differential non-linearity verdict comes from a scan of the histogram. The scan finds the lowest bin, the highest bin and the total. The figure |min DNL| + |max DNL| reduces to 64·(max − min)/total. That figure must not exceed two bins, so the pass test is done as a cross-multiplication with no divider. A clear strobe wipes every counter in one sweep over the bins. The bench and host read the per-channel counters and the bins through two registered read ports.

Top module: `tdc_readout_hist`

## Requirements
- R1: While reset is high and on the first cycle after it, every counter output, both read ports, the mismatch flag, the dead mask, busy, dnl_valid and dnl_pass are zero.
- R2: An accepted header word (word_valid=1, word_is_hdr=1) whose word_hdr differs from exp_hdr in any bit raises hdr_err_cnt by exactly one. The new value is visible after the sampling edge. A matching header does not change hdr_err_cnt.
- R3: evt_cnt counts accepted header words and trig_cnt counts accepted trig strobes, including both in the same cycle. evt_mismatch is high exactly one cycle after the two counts differ.
- R4: An accepted hit word (word_valid=1, word_is_hdr=0) raises the counter of channel word_ch by one. chan_rd_cnt returns the counter selected by chan_rd_sel one cycle later, showing the value held before that edge's update.
- R5: A hit whose word_ch equals hist_sel raises histogram bin word_time by one, and hits on other channels leave the histogram untouched. bin_rd_cnt returns bin bin_rd_sel with the same one-cycle latency as R4.
- R6: Every counter (header errors, events, triggers, channel counters, bins) stops at 2^CNT_W−1 and holds there.
- R7: dead_mask bit c is high one cycle after channel c's low bit equals odd_round while its counter is below HIT_QUOTA. Bits of the other parity are low.
- R8: dnl_req accepted while idle keeps busy high for BINS+1 cycles and clears dnl_valid and dnl_pass. After that, dnl_valid is high and dnl_pass is high only if the total is non-zero and BINS·(max−min) ≤ 2·total.
- R9: clear_req accepted while idle zeroes the header, event and trigger counters and the DNL flags at that edge. It then keeps busy high for max(NCH, BINS) cycles, after which every channel counter and bin reads zero. clear_req wins over a dnl_req in the same cycle.
- R10: Stream words, triggers and requests presented while busy is high change no counter, bin or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_req | input | 1 | Strobe: start the clearing sweep |
| dnl_req | input | 1 | Strobe: start the histogram scan and DNL verdict |
| word_valid | input | 1 | Decoded stream word present |
| word_is_hdr | input | 1 | 1 = header word, 0 = hit word |
| word_hdr | input | HDR_W | Header bits of a header word |
| word_ch | input | $clog2(NCH) | Channel of a hit word |
| word_time | input | TBITS | Time code of a hit word |
| trig | input | 1 | Strobe: one trigger issued |
| exp_hdr | input | HDR_W | Expected header bits |
| hist_sel | input | $clog2(NCH) | Channel that feeds the histogram |
| odd_round | input | 1 | 0 = even channels pulsed, 1 = odd channels pulsed |
| chan_rd_sel | input | $clog2(NCH) | Channel counter read address |
| bin_rd_sel | input | TBITS | Histogram bin read address |
| chan_rd_cnt | output | CNT_W | Registered channel counter read data |
| bin_rd_cnt | output | CNT_W | Registered histogram bin read data |
| hdr_err_cnt | output | CNT_W | Headers that mismatched |
| evt_cnt | output | CNT_W | Events received |
| trig_cnt | output | CNT_W | Triggers issued |
| evt_mismatch | output | 1 | Event and trigger counts differ |
| dead_mask | output | NCH | Pulsed channels below the hit quota |
| busy | output | 1 | Clear sweep or scan in progress |
| dnl_valid | output | 1 | DNL verdict is current |
| dnl_pass | output | 1 | DNL figure within two bins |

## Verification
The counters and busy change at the edge that samples the stimulus. The two read ports, evt_mismatch and dead_mask are one register further on, so they reflect state from before that edge. A DNL verdict appears BINS+1 edges after the accepted request, and a cleared array reads zero once busy falls after max(NCH, BINS) edges. The bench drives inputs and samples outputs at the falling edge. Its behavioural model advances one step per rising edge and computes the one-cycle-late outputs from its state before that step. Every output is therefore compared in exactly the cycle it becomes due.

// File: rtl/tdch_pkg.sv
package tdch_pkg;
  // Sequencer modes for the clearing sweep and the histogram scan
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_CLR  = 2'd1,
    SW_SCAN = 2'd2,
    SW_FIN  = 2'd3
  } sweep_mode_e;
endpackage

// File: rtl/tdch_sweep_ctrl.sv
module tdch_sweep_ctrl
  import tdch_pkg::*;
#(
  parameter int SWEEP_N = 64,
  parameter int SCAN_N  = 64,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_req_i,
  input  logic             dnl_req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             take_o,
  output logic             clr_start_o,
  output logic             scan_start_o,
  output logic             clr_step_o,
  output logic             scan_step_o,
  output logic             fin_o
);
  sweep_mode_e mode_q;
  logic        idle;

  assign idle         = (mode_q == SW_IDLE);
  assign clr_start_o  = idle & clear_req_i;
  assign scan_start_o = idle & ~clear_req_i & dnl_req_i;
  assign take_o       = idle & ~clear_req_i & ~dnl_req_i;
  assign clr_step_o   = (mode_q == SW_CLR);
  assign scan_step_o  = (mode_q == SW_SCAN);
  assign fin_o        = (mode_q == SW_FIN);
  assign busy_o       = ~idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= SW_IDLE;
      idx_o  <= '0;
    end else begin
      unique case (mode_q)
        SW_IDLE: begin
          idx_o <= '0;
          if (clr_start_o)       mode_q <= SW_CLR;
          else if (scan_start_o) mode_q <= SW_SCAN;
        end
        SW_CLR: begin
          if (idx_o == IDX_W'(SWEEP_N - 1)) begin
            mode_q <= SW_IDLE;
            idx_o  <= '0;
          end else begin
            idx_o <= idx_o + IDX_W'(1);
          end
        end
        SW_SCAN: begin
          if (idx_o == IDX_W'(SCAN_N - 1)) begin
            mode_q <= SW_FIN;
            idx_o  <= '0;
          end else begin
            idx_o <= idx_o + IDX_W'(1);
          end
        end
        default: begin
          mode_q <= SW_IDLE;
          idx_o  <= '0;
        end
      endcase
    end
  end

  // R8: the verdict stage only ever follows the last scan step
  assert_fin_after_scan_R8: assert property (@(posedge clk) disable iff (rst)
    fin_o |-> ($past(scan_step_o) && $past(idx_o) == IDX_W'(SCAN_N - 1)));

  // R9: a clear request beats a scan request in the same idle cycle
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (idle && clear_req_i && dnl_req_i) |=> clr_step_o);

endmodule

// File: rtl/tdch_evt_check.sv
module tdch_evt_check #(
  parameter int HDR_W = 8,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  logic             clr_start_i,
  input  logic             hdr_valid_i,
  input  logic [HDR_W-1:0] hdr_bits_i,
  input  logic [HDR_W-1:0] exp_hdr_i,
  input  logic             trig_i,
  output logic [CNT_W-1:0] hdr_err_cnt_o,
  output logic [CNT_W-1:0] evt_cnt_o,
  output logic [CNT_W-1:0] trig_cnt_o,
  output logic             evt_mismatch_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic hdr_bad;
  assign hdr_bad = |(hdr_bits_i ^ exp_hdr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_err_cnt_o  <= '0;
      evt_cnt_o      <= '0;
      trig_cnt_o     <= '0;
      evt_mismatch_o <= 1'b0;
    end else begin
      evt_mismatch_o <= (evt_cnt_o != trig_cnt_o);
      if (clr_start_i) begin
        hdr_err_cnt_o <= '0;
        evt_cnt_o     <= '0;
        trig_cnt_o    <= '0;
      end else if (take_i) begin
        if (hdr_valid_i && evt_cnt_o != CMAX)
          evt_cnt_o <= evt_cnt_o + CNT_W'(1);
        if (hdr_valid_i && hdr_bad && hdr_err_cnt_o != CMAX)
          hdr_err_cnt_o <= hdr_err_cnt_o + CNT_W'(1);
        if (trig_i && trig_cnt_o != CMAX)
          trig_cnt_o <= trig_cnt_o + CNT_W'(1);
      end
    end
  end

  // R2: header errors never advance by more than one per cycle
  assert_hdr_step_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_start_i |=> (hdr_err_cnt_o - $past(hdr_err_cnt_o)) <= CNT_W'(1));

  // R3: equal counts leave the mismatch flag low on the next cycle
  assert_match_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_cnt_o == trig_cnt_o) |=> !evt_mismatch_o);

  // R10: nothing counts while the sequencer holds the stream off
  assert_hold_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (!take_i && !clr_start_i) |=> ($stable(evt_cnt_o) && $stable(trig_cnt_o) && $stable(hdr_err_cnt_o)));

endmodule

// File: rtl/tdch_chan_count.sv
module tdch_chan_count #(
  parameter int NCH       = 32,
  parameter int CNT_W     = 24,
  parameter int HIT_QUOTA = 10000,
  parameter int IDX_W     = 6,
  parameter int CH_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_step_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             hit_i,
  input  logic [CH_W-1:0]  hit_ch_i,
  input  logic             odd_round_i,
  input  logic [CH_W-1:0]  rd_sel_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic [NCH-1:0]   dead_mask_o
);
  localparam logic [CNT_W-1:0] CMAX    = '1;
  localparam logic [CNT_W-1:0] QUOTA_C = CNT_W'(HIT_QUOTA);

  logic [CNT_W-1:0] cnt_q [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) cnt_q[c] <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (clr_step_i && idx_i == IDX_W'(c))
          cnt_q[c] <= '0;
        else if (hit_i && hit_ch_i == CH_W'(c) && cnt_q[c] != CMAX)
          cnt_q[c] <= cnt_q[c] + CNT_W'(1);
      end
    end
  end

  // Liveness verdict: only channels of the pulsed parity can be flagged
  always_ff @(posedge clk) begin
    if (rst) begin
      dead_mask_o <= '0;
    end else begin
      for (int c = 0; c < NCH; c++)
        dead_mask_o[c] <= (1'(c) == odd_round_i) && (cnt_q[c] < QUOTA_C);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_cnt_o <= '0;
    else     rd_cnt_o <= cnt_q[rd_sel_i];
  end

  // R7: at most half the channels belong to one round
  assert_dead_half_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(dead_mask_o) <= (NCH + 1) / 2);

  for (genvar g = 0; g < NCH; g++) begin : g_sat
    // R6: a full channel counter stays full until it is swept
    assert_chan_sat_R6: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[g] == CMAX && !(clr_step_i && idx_i == IDX_W'(g))) |=> cnt_q[g] == CMAX);
  end

endmodule

// File: rtl/tdch_time_hist.sv
module tdch_time_hist #(
  parameter int TBITS = 6,
  parameter int CNT_W = 24,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_step_i,
  input  logic             scan_step_i,
  input  logic             fin_i,
  input  logic             dnl_start_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             hit_i,
  input  logic [TBITS-1:0] hit_bin_i,
  input  logic [TBITS-1:0] rd_sel_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic             dnl_valid_o,
  output logic             dnl_pass_o
);
  localparam int BINS  = 1 << TBITS;
  localparam int TOT_W = CNT_W + TBITS;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] hist_q [BINS];
  logic [CNT_W-1:0] scan_val;
  logic [CNT_W-1:0] mn_q, mx_q;
  logic [TOT_W-1:0] tot_q;
  logic [TOT_W:0]   spread_scaled, limit_scaled;
  logic [TBITS-1:0] scan_bin;

  assign scan_bin = idx_i[TBITS-1:0];
  assign scan_val = hist_q[scan_bin];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < BINS; b++) hist_q[b] <= '0;
    end else begin
      for (int b = 0; b < BINS; b++) begin
        if (clr_step_i && scan_bin == TBITS'(b))
          hist_q[b] <= '0;
        else if (hit_i && hit_bin_i == TBITS'(b) && hist_q[b] != CMAX)
          hist_q[b] <= hist_q[b] + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_cnt_o <= '0;
    else     rd_cnt_o <= hist_q[rd_sel_i];
  end

  // One bin per cycle: running minimum, maximum and total
  always_ff @(posedge clk) begin
    if (rst) begin
      mn_q  <= '0;
      mx_q  <= '0;
      tot_q <= '0;
    end else if (scan_step_i) begin
      if (scan_bin == '0) begin
        mn_q  <= scan_val;
        mx_q  <= scan_val;
        tot_q <= TOT_W'(scan_val);
      end else begin
        if (scan_val < mn_q) mn_q <= scan_val;
        if (scan_val > mx_q) mx_q <= scan_val;
        tot_q <= tot_q + TOT_W'(scan_val);
      end
    end
  end

  // |min DNL| + |max DNL| <= 2  <=>  BINS*(max-min) <= 2*total
  assign spread_scaled = {1'b0, mx_q - mn_q, {TBITS{1'b0}}};
  assign limit_scaled  = {tot_q, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      dnl_valid_o <= 1'b0;
      dnl_pass_o  <= 1'b0;
    end else if (dnl_start_i) begin
      dnl_valid_o <= 1'b0;
      dnl_pass_o  <= 1'b0;
    end else if (fin_i) begin
      dnl_valid_o <= 1'b1;
      dnl_pass_o  <= (tot_q != '0) && (spread_scaled <= limit_scaled);
    end
  end

  // R8: a pass is only ever reported with a current verdict
  assert_pass_needs_valid_R8: assert property (@(posedge clk) disable iff (rst)
    dnl_pass_o |-> dnl_valid_o);

  // R10: the stream never feeds the histogram while it is being scanned
  assert_no_hit_in_scan_R10: assert property (@(posedge clk) disable iff (rst)
    scan_step_i |-> !hit_i);

  for (genvar g = 0; g < BINS; g++) begin : g_sat
    // R6: a full bin stays full until it is swept
    assert_bin_sat_R6: assert property (@(posedge clk) disable iff (rst)
      (hist_q[g] == CMAX && !(clr_step_i && scan_bin == TBITS'(g))) |=> hist_q[g] == CMAX);
  end

endmodule

// File: rtl/tdc_readout_hist.sv
module tdc_readout_hist #(
  parameter int NCH       = 32,
  parameter int TBITS     = 6,
  parameter int HDR_W     = 8,
  parameter int CNT_W     = 24,
  parameter int HIT_QUOTA = 10000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear_req,
  input  logic                   dnl_req,
  input  logic                   word_valid,
  input  logic                   word_is_hdr,
  input  logic [HDR_W-1:0]       word_hdr,
  input  logic [$clog2(NCH)-1:0] word_ch,
  input  logic [TBITS-1:0]       word_time,
  input  logic                   trig,
  input  logic [HDR_W-1:0]       exp_hdr,
  input  logic [$clog2(NCH)-1:0] hist_sel,
  input  logic                   odd_round,
  input  logic [$clog2(NCH)-1:0] chan_rd_sel,
  input  logic [TBITS-1:0]       bin_rd_sel,
  output logic [CNT_W-1:0]       chan_rd_cnt,
  output logic [CNT_W-1:0]       bin_rd_cnt,
  output logic [CNT_W-1:0]       hdr_err_cnt,
  output logic [CNT_W-1:0]       evt_cnt,
  output logic [CNT_W-1:0]       trig_cnt,
  output logic                   evt_mismatch,
  output logic [NCH-1:0]         dead_mask,
  output logic                   busy,
  output logic                   dnl_valid,
  output logic                   dnl_pass
);
  localparam int CH_W    = $clog2(NCH);
  localparam int BINS    = 1 << TBITS;
  localparam int SWEEP_N = (NCH > BINS) ? NCH : BINS;
  localparam int IDX_W   = $clog2(SWEEP_N);

  logic [IDX_W-1:0] idx;
  logic take, clr_start, scan_start, clr_step, scan_step, fin;
  logic hdr_v, hit_v, hist_v;

  assign hdr_v  = word_valid & word_is_hdr;
  assign hit_v  = take & word_valid & ~word_is_hdr;
  assign hist_v = hit_v & (word_ch == hist_sel);

  tdch_sweep_ctrl #(
    .SWEEP_N(SWEEP_N), .SCAN_N(BINS), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .clear_req_i(clear_req), .dnl_req_i(dnl_req),
    .idx_o(idx), .busy_o(busy), .take_o(take),
    .clr_start_o(clr_start), .scan_start_o(scan_start),
    .clr_step_o(clr_step), .scan_step_o(scan_step), .fin_o(fin)
  );

  tdch_evt_check #(
    .HDR_W(HDR_W), .CNT_W(CNT_W)
  ) u_evt (
    .clk(clk), .rst(rst),
    .take_i(take), .clr_start_i(clr_start),
    .hdr_valid_i(hdr_v), .hdr_bits_i(word_hdr), .exp_hdr_i(exp_hdr),
    .trig_i(trig),
    .hdr_err_cnt_o(hdr_err_cnt), .evt_cnt_o(evt_cnt), .trig_cnt_o(trig_cnt),
    .evt_mismatch_o(evt_mismatch)
  );

  tdch_chan_count #(
    .NCH(NCH), .CNT_W(CNT_W), .HIT_QUOTA(HIT_QUOTA), .IDX_W(IDX_W), .CH_W(CH_W)
  ) u_chan (
    .clk(clk), .rst(rst),
    .clr_step_i(clr_step), .idx_i(idx),
    .hit_i(hit_v), .hit_ch_i(word_ch),
    .odd_round_i(odd_round), .rd_sel_i(chan_rd_sel),
    .rd_cnt_o(chan_rd_cnt), .dead_mask_o(dead_mask)
  );

  tdch_time_hist #(
    .TBITS(TBITS), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_hist (
    .clk(clk), .rst(rst),
    .clr_step_i(clr_step), .scan_step_i(scan_step), .fin_i(fin),
    .dnl_start_i(clr_start | scan_start), .idx_i(idx),
    .hit_i(hist_v), .hit_bin_i(word_time), .rd_sel_i(bin_rd_sel),
    .rd_cnt_o(bin_rd_cnt), .dnl_valid_o(dnl_valid), .dnl_pass_o(dnl_pass)
  );

endmodule

// File: tb/tdc_readout_hist_bench.sv
module tdc_readout_hist_bench;
  localparam int NCH = 32, TBITS = 6, HDR_W = 8, CNT_W = 8, QUOTA = 12;
  localparam int CH_W = 5, BINS = 64, SWEEP = 64, CMAX = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear_req = 0, dnl_req = 0, word_valid = 0, word_is_hdr = 0, trig = 0, odd_round = 0;
  logic [HDR_W-1:0] word_hdr = '0, exp_hdr = '0;
  logic [CH_W-1:0]  word_ch = '0, hist_sel = '0, chan_rd_sel = '0;
  logic [TBITS-1:0] word_time = '0, bin_rd_sel = '0;
  logic [CNT_W-1:0] chan_rd_cnt, bin_rd_cnt, hdr_err_cnt, evt_cnt, trig_cnt;
  logic evt_mismatch, busy, dnl_valid, dnl_pass;
  logic [NCH-1:0] dead_mask;

  always #10 clk = ~clk;

  tdc_readout_hist #(.NCH(NCH), .TBITS(TBITS), .HDR_W(HDR_W), .CNT_W(CNT_W), .HIT_QUOTA(QUOTA))
  u_tdc_readout_hist (
    .clk(clk), .rst(rst), .clear_req(clear_req), .dnl_req(dnl_req),
    .word_valid(word_valid), .word_is_hdr(word_is_hdr), .word_hdr(word_hdr),
    .word_ch(word_ch), .word_time(word_time), .trig(trig), .exp_hdr(exp_hdr),
    .hist_sel(hist_sel), .odd_round(odd_round), .chan_rd_sel(chan_rd_sel),
    .bin_rd_sel(bin_rd_sel), .chan_rd_cnt(chan_rd_cnt), .bin_rd_cnt(bin_rd_cnt),
    .hdr_err_cnt(hdr_err_cnt), .evt_cnt(evt_cnt), .trig_cnt(trig_cnt),
    .evt_mismatch(evt_mismatch), .dead_mask(dead_mask), .busy(busy),
    .dnl_valid(dnl_valid), .dnl_pass(dnl_pass)
  );

  int errors = 0, checks = 0, cyc_n = 0;
  string phase = "R1";
  bit done = 0;

  // Behavioural reference state
  int m_hdr, m_evt, m_trig, m_chan[NCH], m_bin[BINS];
  int m_mode, m_idx, m_mn, m_mx, m_tot, m_dv, m_dp;
  // Expected outputs after the coming edge
  int e_hdr, e_evt, e_trig, e_mis, e_crd, e_brd, e_busy, e_dv, e_dp;
  longint e_dead;

  task automatic model_reset();
    m_hdr = 0; m_evt = 0; m_trig = 0; m_mode = 0; m_idx = 0;
    m_mn = 0; m_mx = 0; m_tot = 0; m_dv = 0; m_dp = 0;
    for (int c = 0; c < NCH; c++) m_chan[c] = 0;
    for (int b = 0; b < BINS; b++) m_bin[b] = 0;
  endtask

  function automatic int sat1(int v);
    return (v < CMAX) ? v + 1 : v;
  endfunction

  task automatic model_step();
    if (rst) begin
      model_reset();
      e_crd = 0; e_brd = 0; e_mis = 0; e_dead = 0;
    end else begin
      e_crd = m_chan[chan_rd_sel];
      e_brd = m_bin[bin_rd_sel];
      e_mis = (m_evt != m_trig);
      e_dead = 0;
      for (int c = 0; c < NCH; c++)
        if ((c % 2) == int'(odd_round) && m_chan[c] < QUOTA) e_dead |= (64'd1 << c);
      case (m_mode)
        0: begin
          if (clear_req) begin
            m_hdr = 0; m_evt = 0; m_trig = 0; m_dv = 0; m_dp = 0; m_mode = 1; m_idx = 0;
          end else if (dnl_req) begin
            m_dv = 0; m_dp = 0; m_mode = 2; m_idx = 0;
          end else begin
            if (word_valid && word_is_hdr) begin
              m_evt = sat1(m_evt);
              if (word_hdr != exp_hdr) m_hdr = sat1(m_hdr);
            end
            if (word_valid && !word_is_hdr) begin
              m_chan[word_ch] = sat1(m_chan[word_ch]);
              if (word_ch == hist_sel) m_bin[word_time] = sat1(m_bin[word_time]);
            end
            if (trig) m_trig = sat1(m_trig);
          end
        end
        1: begin
          m_bin[m_idx] = 0;
          if (m_idx < NCH) m_chan[m_idx] = 0;
          if (m_idx == SWEEP - 1) m_mode = 0; else m_idx++;
        end
        2: begin
          if (m_idx == 0) begin
            m_mn = m_bin[0]; m_mx = m_bin[0]; m_tot = m_bin[0];
          end else begin
            if (m_bin[m_idx] < m_mn) m_mn = m_bin[m_idx];
            if (m_bin[m_idx] > m_mx) m_mx = m_bin[m_idx];
            m_tot += m_bin[m_idx];
          end
          if (m_idx == BINS - 1) begin m_mode = 3; m_idx = 0; end else m_idx++;
        end
        default: begin
          m_dv = 1;
          m_dp = (m_tot != 0 && BINS * (m_mx - m_mn) <= 2 * m_tot) ? 1 : 0;
          m_mode = 0;
        end
      endcase
    end
    e_hdr = m_hdr; e_evt = m_evt; e_trig = m_trig;
    e_busy = (m_mode != 0); e_dv = m_dv; e_dp = m_dp;
  endtask

  task automatic check(string name, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", phase, name, act, exp, cyc_n);
    end
  endtask

  task automatic compare_all();
    check("hdr_err_cnt", hdr_err_cnt, e_hdr);
    check("evt_cnt", evt_cnt, e_evt);
    check("trig_cnt", trig_cnt, e_trig);
    check("evt_mismatch", evt_mismatch, e_mis);
    check("chan_rd_cnt", chan_rd_cnt, e_crd);
    check("bin_rd_cnt", bin_rd_cnt, e_brd);
    check("dead_mask", {32'd0, dead_mask}, e_dead);
    check("busy", busy, e_busy);
    check("dnl_valid", dnl_valid, e_dv);
    check("dnl_pass", dnl_pass, e_dp);
  endtask

  // One clock: inputs are already set at the falling edge
  task automatic cyc();
    cyc_n++;
    chan_rd_sel = CH_W'(cyc_n);
    bin_rd_sel  = TBITS'(cyc_n * 7);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    word_valid = 0; trig = 0; clear_req = 0; dnl_req = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic send_hdr(logic [HDR_W-1:0] h, logic t);
    word_valid = 1; word_is_hdr = 1; word_hdr = h; trig = t; cyc();
  endtask

  task automatic send_hit(int ch, int tm, logic t);
    word_valid = 1; word_is_hdr = 0; word_ch = CH_W'(ch); word_time = TBITS'(tm); trig = t; cyc();
  endtask

  // Feed ignored stimulus while the model says the block is busy (R10)
  task automatic run_busy();
    for (int i = 0; i < 200 && m_mode != 0; i++) begin
      word_valid = 1; word_is_hdr = i[0]; word_hdr = 8'h11; word_ch = hist_sel;
      word_time = TBITS'(i); trig = 1; dnl_req = i[1]; clear_req = i[2];
      cyc();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    phase = "R1";
    idle(3);
    rst = 0;
    idle(1);

    phase = "R2";
    exp_hdr = 8'hA5;
    send_hdr(8'hA5, 1); send_hdr(8'h5A, 1); send_hdr(8'hA5, 0); send_hdr(8'hA4, 1);
    idle(2);

    phase = "R3";
    send_hdr(8'hA5, 0);
    trig = 1; cyc();
    idle(2);
    trig = 1; cyc(); trig = 1; cyc();
    send_hdr(8'hA5, 1);
    idle(2);

    phase = "R4";
    hist_sel = 5'd3;
    for (int i = 0; i < 41; i++) send_hit(i % NCH, (i * 5) % BINS, i[0]);
    idle(40);

    phase = "R5";
    for (int i = 0; i < 6; i++) send_hit(3, 15 + (i % 2), 0);
    send_hit(4, 15, 0);
    idle(70);

    phase = "R7";
    odd_round = 0;
    for (int r = 0; r < QUOTA; r++)
      for (int c = 0; c < NCH; c += 2)
        if (!(c == 6 && r >= 5)) send_hit(c, (r * 5 + c) % BINS, 0);
    idle(3);
    odd_round = 1;
    idle(3);
    for (int r = 0; r < QUOTA; r++)
      for (int c = 1; c < NCH; c += 2)
        if (c != 9) send_hit(c, r, 0);
    idle(3);

    phase = "R9";
    clear_req = 1; dnl_req = 1; word_valid = 1; word_is_hdr = 0; word_ch = 5'd3; trig = 1;
    cyc();
    phase = "R10";
    run_busy();
    phase = "R9";
    idle(70);

    phase = "R8";
    hist_sel = 5'd5;
    dnl_req = 1; cyc();
    run_busy();
    idle(2);
    for (int r = 0; r < 4; r++)
      for (int b = 0; b < BINS; b++) send_hit(5, b, 0);
    dnl_req = 1; cyc();
    run_busy();
    idle(2);
    for (int i = 0; i < 3; i++) send_hit(5, 10, 0);
    dnl_req = 1; cyc();
    run_busy();
    idle(2);
    for (int i = 0; i < 20; i++) send_hit(5, 20, 0);
    dnl_req = 1; cyc();
    run_busy();
    idle(2);

    phase = "R6";
    for (int i = 0; i < 270; i++) send_hit(5, 7, 0);
    for (int i = 0; i < 260; i++) send_hdr(8'h00, 1);
    idle(70);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule